// File: doc/BRIEF.md
# Dual-Processor Mailbox and Semaphore Unit

This block sits between a main CPU and a coprocessor. Each processor has its own synchronous register port with an address, write and read strobes, write data and registered read data. Through these ports the two sides share a bank of 32 semaphore flags and exchange one-word messages in two mailboxes. The inbox carries words from the coprocessor to the CPU. The outbox carries words from the CPU to the coprocessor.

Each mailbox is a two-state machine with the states MB_EMPTY and MB_FULL, and the state is visible as the tag bit of the word. It has three transitions. LOAD goes from MB_EMPTY to MB_FULL when the sender writes. DRAIN goes from MB_FULL to MB_EMPTY when the receiver reads without a write in the same cycle. RELOAD stays in MB_FULL when the sender writes over an unread word. Every other case holds the state.

The semaphore bank has three views. A read-only status word shows the flags. A write-one-to-set address raises flags and a write-one-to-clear address lowers them. Either port may use any of the three. One interrupt line goes to each processor. Each line is driven by the full or empty condition of a mailbox together with the enable bits stored in that mailbox word.

Top module: `ipc_mbox_sema`

## Requirements
- R1: After reset the semaphore flags, both mailbox words, both read data outputs and both interrupt lines are zero.
- R2: A read at byte offset 0x00 from either port returns the semaphore flags, zero-extended to 32 bits. A write to offset 0x00 changes nothing.
- R3: Writing to offset 0x04 sets every flag whose write-data bit is 1. Flags whose bit is 0 keep their value.
- R4: Writing to offset 0x08 clears every flag whose write-data bit is 1. Flags whose bit is 0 keep their value.
- R5: If one port sets a flag and the other port clears the same flag in the same cycle, the flag ends up set. Clears of other flags in that cycle still take effect.
- R6: The mailbox word has the following layout:
  - bit 31: full-interrupt enable
  - bit 30: empty-interrupt enable
  - bit 29: tag, where 1 means full
  - bit 28: reserved, always reads 0
  - bits 27:0: payload
  
  A sender write loads bits 31:30 and 27:0 from the write data and sets the tag. Write-data bits 29:28 are ignored. The coprocessor is the sender at offset 0x10 (inbox). The CPU is the sender at offset 0x20 (outbox).
- R7: A read by the receiver (the CPU for the inbox, the coprocessor for the outbox) returns the word as it was before the read, then clears the tag. A read by the sender leaves the tag unchanged.
- R8: A write by the receiver to its incoming mailbox has no effect.
- R9: `cpu_irq` is 1 exactly when the inbox is full with bit 31 set, or the outbox is empty with bit 30 set.
- R10: `cop_irq` is 1 exactly when the outbox is full with bit 31 set, or the inbox is empty with bit 30 set.
- R11: Reads of any offset other than 0x00, 0x04, 0x08, 0x10 and 0x20 return 0, and writes to those offsets change nothing. Reads of the write-only offsets 0x04 and 0x08 return 0.
- R12: Read data appears on the port's read data output in the cycle after the read strobe. It is 0 in any cycle that does not follow a read.
- R13: If the sender writes and the receiver reads the same mailbox in the same cycle, the read returns the old word and the mailbox ends up full, holding the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | CPU byte offset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 32 | CPU read data, one cycle after the strobe |
| cop_addr | input | ADDR_W | Coprocessor byte offset |
| cop_wr | input | 1 | Coprocessor write strobe |
| cop_wdata | input | 32 | Coprocessor write data |
| cop_rd | input | 1 | Coprocessor read strobe |
| cop_rdata | output | 32 | Coprocessor read data, one cycle after the strobe |
| cpu_irq | output | 1 | Interrupt to the CPU |
| cop_irq | output | 1 | Interrupt to the coprocessor |

## Verification
Two pairs of operations can land in the same clock edge.

The first pair is a set from one port and a clear from the other on the same semaphore flag. The bench drives both ports in one cycle, with a clear mask that also covers a second flag. It then reads the status and expects the contested flag set and the other flag cleared.

The second pair is a sender write and a receiver read on the same mailbox. The bench issues both in one cycle. It expects the read to return the old word with its tag at 0, and a later read to return the new word with the tag at 1.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int WORD_W = 32;

    localparam logic [31:0] OFS_STAT   = 32'h00;
    localparam logic [31:0] OFS_SET    = 32'h04;
    localparam logic [31:0] OFS_CLR    = 32'h08;
    localparam logic [31:0] OFS_INBOX  = 32'h10;
    localparam logic [31:0] OFS_OUTBOX = 32'h20;

    localparam int BIT_EN_FULL  = 31;
    localparam int BIT_EN_EMPTY = 30;
    localparam int BIT_TAG      = 29;
    localparam int BIT_RSVD     = 28;
    localparam int PAY_W        = 28;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_SET,
        SEL_CLR,
        SEL_INBOX,
        SEL_OUTBOX
    } reg_sel_e;

    typedef enum logic {
        MB_EMPTY = 1'b0,
        MB_FULL  = 1'b1
    } mb_state_e;

    function automatic reg_sel_e decode(input logic [31:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_STAT:   s = SEL_STAT;
            OFS_SET:    s = SEL_SET;
            OFS_CLR:    s = SEL_CLR;
            OFS_INBOX:  s = SEL_INBOX;
            OFS_OUTBOX: s = SEL_OUTBOX;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ipc_sema_bank.sv
module ipc_sema_bank #(
    parameter int SEMA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEMA_W-1:0] set_a,
    input  logic [SEMA_W-1:0] set_b,
    input  logic [SEMA_W-1:0] clr_a,
    input  logic [SEMA_W-1:0] clr_b,
    output logic [SEMA_W-1:0] flags_o
);

    logic [SEMA_W-1:0] set_any;
    logic [SEMA_W-1:0] clr_any;

    assign set_any = set_a | set_b;
    assign clr_any = clr_a | clr_b;

    for (genvar i = 0; i < SEMA_W; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set_any[i]) begin
                flag_q <= 1'b1;      // set has priority over clear
            end else if (clr_any[i]) begin
                flag_q <= 1'b0;
            end
        end
        assign flags_o[i] = flag_q;
    end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_wr,
    input  logic [WORD_W-1:0] snd_wdata,
    input  logic              rcv_rd,
    output logic [WORD_W-1:0] word_o,
    output logic              full_irq_o,
    output logic              empty_irq_o
);

    mb_state_e         state_q;
    mb_state_e         state_d;
    logic              en_full_q;
    logic              en_empty_q;
    logic [PAY_W-1:0]  payload_q;
    wire               unused_tag_bits = ^snd_wdata[BIT_TAG:BIT_RSVD];

    // next state: LOAD, RELOAD, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_EMPTY: begin
                if (snd_wr) state_d = MB_FULL;
            end
            MB_FULL: begin
                if (snd_wr)      state_d = MB_FULL;
                else if (rcv_rd) state_d = MB_EMPTY;
            end
            default: state_d = MB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MB_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_full_q  <= 1'b0;
            en_empty_q <= 1'b0;
            payload_q  <= '0;
        end else if (snd_wr) begin
            en_full_q  <= snd_wdata[BIT_EN_FULL];
            en_empty_q <= snd_wdata[BIT_EN_EMPTY];
            payload_q  <= snd_wdata[PAY_W-1:0];
        end
    end

    always_comb begin
        word_o      = {en_full_q, en_empty_q, 1'b0, 1'b0, payload_q};
        full_irq_o  = 1'b0;
        empty_irq_o = 1'b0;
        unique case (state_q)
            MB_EMPTY: empty_irq_o = en_empty_q;
            MB_FULL: begin
                word_o[BIT_TAG] = 1'b1;
                full_irq_o      = en_full_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ipc_rd_port.sv
module ipc_rd_port
    import ipc_pkg::*;
#(
    parameter int SEMA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  reg_sel_e          sel,
    input  logic [SEMA_W-1:0] flags,
    input  logic [WORD_W-1:0] inbox_word,
    input  logic [WORD_W-1:0] outbox_word,
    output logic [WORD_W-1:0] rdata_o
);

    logic [WORD_W-1:0] mux_d;

    always_comb begin
        mux_d = '0;
        unique case (sel)
            SEL_STAT:   mux_d = WORD_W'(flags);
            SEL_INBOX:  mux_d = inbox_word;
            SEL_OUTBOX: mux_d = outbox_word;
            default:    mux_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_o <= '0;
        else        rdata_o <= rd ? mux_d : '0;
    end

endmodule

// File: rtl/ipc_mbox_sema.sv
module ipc_mbox_sema
    import ipc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SEMA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [31:0]       cpu_wdata,
    input  logic              cpu_rd,
    output logic [31:0]       cpu_rdata,
    input  logic [ADDR_W-1:0] cop_addr,
    input  logic              cop_wr,
    input  logic [31:0]       cop_wdata,
    input  logic              cop_rd,
    output logic [31:0]       cop_rdata,
    output logic              cpu_irq,
    output logic              cop_irq
);

    reg_sel_e          cpu_sel;
    reg_sel_e          cop_sel;
    logic [SEMA_W-1:0] sema_q;
    logic [WORD_W-1:0] ib_word;
    logic [WORD_W-1:0] ob_word;
    logic              ib_full_irq, ib_empty_irq;
    logic              ob_full_irq, ob_empty_irq;
    logic [SEMA_W-1:0] cpu_set, cpu_clr, cop_set, cop_clr;

    assign cpu_sel = decode(32'(cpu_addr));
    assign cop_sel = decode(32'(cop_addr));

    assign cpu_set = (cpu_wr && cpu_sel == SEL_SET) ? cpu_wdata[SEMA_W-1:0] : '0;
    assign cpu_clr = (cpu_wr && cpu_sel == SEL_CLR) ? cpu_wdata[SEMA_W-1:0] : '0;
    assign cop_set = (cop_wr && cop_sel == SEL_SET) ? cop_wdata[SEMA_W-1:0] : '0;
    assign cop_clr = (cop_wr && cop_sel == SEL_CLR) ? cop_wdata[SEMA_W-1:0] : '0;

    ipc_sema_bank #(.SEMA_W(SEMA_W)) u_sema (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_a   (cpu_set),
        .set_b   (cop_set),
        .clr_a   (cpu_clr),
        .clr_b   (cop_clr),
        .flags_o (sema_q)
    );

    // inbox: coprocessor sends, CPU receives
    ipc_mailbox u_inbox (
        .clk         (clk),
        .rst_n       (rst_n),
        .snd_wr      (cop_wr && cop_sel == SEL_INBOX),
        .snd_wdata   (cop_wdata),
        .rcv_rd      (cpu_rd && cpu_sel == SEL_INBOX),
        .word_o      (ib_word),
        .full_irq_o  (ib_full_irq),
        .empty_irq_o (ib_empty_irq)
    );

    // outbox: CPU sends, coprocessor receives
    ipc_mailbox u_outbox (
        .clk         (clk),
        .rst_n       (rst_n),
        .snd_wr      (cpu_wr && cpu_sel == SEL_OUTBOX),
        .snd_wdata   (cpu_wdata),
        .rcv_rd      (cop_rd && cop_sel == SEL_OUTBOX),
        .word_o      (ob_word),
        .full_irq_o  (ob_full_irq),
        .empty_irq_o (ob_empty_irq)
    );

    ipc_rd_port #(.SEMA_W(SEMA_W)) u_cpu_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd          (cpu_rd),
        .sel         (cpu_sel),
        .flags       (sema_q),
        .inbox_word  (ib_word),
        .outbox_word (ob_word),
        .rdata_o     (cpu_rdata)
    );

    ipc_rd_port #(.SEMA_W(SEMA_W)) u_cop_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd          (cop_rd),
        .sel         (cop_sel),
        .flags       (sema_q),
        .inbox_word  (ib_word),
        .outbox_word (ob_word),
        .rdata_o     (cop_rdata)
    );

    assign cpu_irq = ib_full_irq | ob_empty_irq;
    assign cop_irq = ob_full_irq | ib_empty_irq;

endmodule

// File: rtl/ipc_mbox_sema_chk.sv
module ipc_mbox_sema_chk
    import ipc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SEMA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic [31:0]       cpu_wdata,
    input logic              cpu_rd,
    input logic [31:0]       cpu_rdata,
    input logic [ADDR_W-1:0] cop_addr,
    input logic              cop_wr,
    input logic              cop_rd,
    input logic              cpu_irq,
    input logic              cop_irq,
    input logic [SEMA_W-1:0] sema_q,
    input logic [31:0]       ib_word,
    input logic [31:0]       ob_word
);

    AST_SEMA_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && 32'(cpu_addr) == OFS_SET) |=>
        ((sema_q & $past(cpu_wdata[SEMA_W-1:0])) == $past(cpu_wdata[SEMA_W-1:0]))); // R3

    AST_TAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_wr && 32'(cop_addr) == OFS_INBOX) |=> ib_word[BIT_TAG]); // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ib_word[BIT_RSVD] && !ob_word[BIT_RSVD]); // R6

    AST_TAG_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && 32'(cpu_addr) == OFS_INBOX &&
         !(cop_wr && 32'(cop_addr) == OFS_INBOX)) |=> !ib_word[BIT_TAG]); // R7

    AST_OB_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_rd && 32'(cop_addr) == OFS_OUTBOX &&
         !(cpu_wr && 32'(cpu_addr) == OFS_OUTBOX)) |=> !ob_word[BIT_TAG]); // R7

    AST_CPU_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == ((ib_word[BIT_TAG] && ib_word[BIT_EN_FULL]) ||
                    (!ob_word[BIT_TAG] && ob_word[BIT_EN_EMPTY]))); // R9

    AST_COP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        cop_irq == ((ob_word[BIT_TAG] && ob_word[BIT_EN_FULL]) ||
                    (!ib_word[BIT_TAG] && ib_word[BIT_EN_EMPTY]))); // R10

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> (cpu_rdata == 32'h0)); // R12

endmodule

bind ipc_mbox_sema ipc_mbox_sema_chk #(.ADDR_W(ADDR_W), .SEMA_W(SEMA_W)) u_chk (.*);

// File: tb/ipc_mbox_sema_test.sv
`timescale 1ns/1ps
module ipc_mbox_sema_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cpu_addr = '0, cop_addr = '0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0, cop_wr = 1'b0, cop_rd = 1'b0;
    logic [31:0] cpu_wdata = '0, cop_wdata = '0;
    logic [31:0] cpu_rdata, cop_rdata;
    logic        cpu_irq, cop_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ipc_mbox_sema uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .cop_addr(cop_addr), .cop_wr(cop_wr), .cop_wdata(cop_wdata),
        .cop_rd(cop_rd), .cop_rdata(cop_rdata),
        .cpu_irq(cpu_irq), .cop_irq(cop_irq)
    );

    typedef struct packed {
        logic        port;   // 0 cpu, 1 cop
        logic [1:0]  op;     // 0 idle, 1 write, 2 read
        logic [5:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [1:0]  irq;    // {cpu_irq, cop_irq}
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd1, 6'h04, 32'h0000_00F1, 32'h0, 2'b00},         // R3 set
        '{1'b1, 2'd2, 6'h00, 32'h0, 32'h0000_00F1, 2'b00},         // R2 status
        '{1'b1, 2'd1, 6'h08, 32'h0000_0011, 32'h0, 2'b00},         // R4 clear
        '{1'b0, 2'd2, 6'h00, 32'h0, 32'h0000_00E0, 2'b00},         // R2 R4
        '{1'b1, 2'd1, 6'h10, 32'h8ABC_DEF5, 32'h0, 2'b10},         // R6 R9 inbox load
        '{1'b1, 2'd2, 6'h10, 32'h0, 32'hAABC_DEF5, 2'b10},         // R7 sender read
        '{1'b0, 2'd2, 6'h10, 32'h0, 32'hAABC_DEF5, 2'b00},         // R7 receiver read
        '{1'b0, 2'd2, 6'h10, 32'h0, 32'h8ABC_DEF5, 2'b00},         // R7 tag cleared
        '{1'b1, 2'd1, 6'h10, 32'h7000_0001, 32'h0, 2'b00},         // R6 tag/rsvd ignored
        '{1'b0, 2'd2, 6'h10, 32'h0, 32'h6000_0001, 2'b01},         // R10 inbox empty irq
        '{1'b0, 2'd1, 6'h10, 32'hFFFF_FFFF, 32'h0, 2'b01},         // R8 receiver write
        '{1'b1, 2'd2, 6'h10, 32'h0, 32'h4000_0001, 2'b01},         // R8 unchanged
        '{1'b0, 2'd1, 6'h20, 32'hC123_4567, 32'h0, 2'b01},         // R6 R10 outbox load
        '{1'b1, 2'd2, 6'h20, 32'h0, 32'hE123_4567, 2'b11},         // R7 R9 outbox drained
        '{1'b1, 2'd1, 6'h10, 32'h0000_0000, 32'h0, 2'b10},         // R10 inbox full no enable
        '{1'b0, 2'd1, 6'h0C, 32'hFFFF_FFFF, 32'h0, 2'b10},         // R11 reserved write
        '{1'b0, 2'd2, 6'h0C, 32'h0, 32'h0, 2'b10},                 // R11 reserved read
        '{1'b1, 2'd2, 6'h14, 32'h0, 32'h0, 2'b10},                 // R11 reserved read
        '{1'b0, 2'd2, 6'h04, 32'h0, 32'h0, 2'b10},                 // R11 write-only read
        '{1'b1, 2'd1, 6'h00, 32'hFFFF_FFFF, 32'h0, 2'b10},         // R2 status write
        '{1'b1, 2'd2, 6'h00, 32'h0, 32'h0000_00E0, 2'b10}          // R2 R11 unchanged
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        cpu_wr = 0; cpu_rd = 0; cop_wr = 0; cop_rd = 0;
        cpu_addr = '0; cop_addr = '0; cpu_wdata = '0; cop_wdata = '0;
    endtask

    task automatic drive(input logic port, input logic [1:0] op,
                         input logic [5:0] addr, input logic [31:0] wd);
        if (!port) begin
            cpu_addr = addr; cpu_wdata = wd;
            cpu_wr = (op == 2'd1); cpu_rd = (op == 2'd2);
        end else begin
            cop_addr = addr; cop_wdata = wd;
            cop_wr = (op == 2'd1); cop_rd = (op == 2'd2);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cpu_rdata", cpu_rdata, 32'h0);
        chk("R1 cop_rdata", cop_rdata, 32'h0);
        chk("R1 irqs", {30'h0, cpu_irq, cop_irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            idle();
            drive(VEC[i].port, VEC[i].op, VEC[i].addr, VEC[i].wdata);
            @(negedge clk);
            if (VEC[i].op == 2'd2)
                chk($sformatf("R2/R7/R11 vec%0d rdata", i),
                    VEC[i].port ? cop_rdata : cpu_rdata, VEC[i].exp);
            else
                chk($sformatf("R12 vec%0d idle rdata", i), cpu_rdata | cop_rdata, 32'h0);
            chk($sformatf("R9/R10 vec%0d irq", i), {30'h0, cpu_irq, cop_irq},
                {30'h0, VEC[i].irq});
        end

        // R5: set bit 5 from CPU, clear bits 5 and 7 from COP in one cycle
        idle();
        drive(1'b0, 2'd1, 6'h04, 32'h0000_0020);
        drive(1'b1, 2'd1, 6'h08, 32'h0000_00A0);
        @(negedge clk);
        idle();
        drive(1'b0, 2'd2, 6'h00, 32'h0);
        @(negedge clk);
        chk("R5 set wins", cpu_rdata, 32'h0000_0060);

        // R13: CPU writes outbox while COP reads it
        idle();
        drive(1'b0, 2'd1, 6'h20, 32'h0000_0055);
        drive(1'b1, 2'd2, 6'h20, 32'h0);
        @(negedge clk);
        chk("R13 old word", cop_rdata, 32'hC123_4567);
        idle();
        drive(1'b1, 2'd2, 6'h20, 32'h0);
        @(negedge clk);
        chk("R13 new word full", cop_rdata, 32'h2000_0055);
        idle();
        @(negedge clk);
        chk("R12 zero after idle", cop_rdata, 32'h0);

        // R1: reset in mid-run clears state and irq
        drive(1'b1, 2'd1, 6'h10, 32'h8000_0000);
        @(negedge clk);
        idle();
        chk("R9 inbox full irq", {31'h0, cpu_irq}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 irqs after reset", {30'h0, cpu_irq, cop_irq}, 32'h0);
        rst_n = 1'b1;
        drive(1'b0, 2'd2, 6'h00, 32'h0);
        @(negedge clk);
        chk("R1 sema zero", cpu_rdata, 32'h0);
        idle();
        drive(1'b0, 2'd2, 6'h10, 32'h0);
        @(negedge clk);
        chk("R1 inbox zero", cpu_rdata, 32'h0);
        idle();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule